// File: doc/BRIEF.md
# Current-Channel Alert and Status Logic

This block sits behind a power monitor's converter and its hot-swap controller. Each time a current-channel conversion completes, it compares the upper byte of the result with a programmable threshold. It also follows the switch's overcurrent turn-off events and the off request. From these it keeps three sticky alert flags, an active-high alert line and a six-bit status word. The register interface is not part of this block. Control values arrive as plain level ports, and the clear bit arrives as a one-cycle strobe, which models a self-clearing register bit.

The current trip has two modes. In single-sample mode, one conversion above the threshold raises the converter alert. In run mode, the alert is raised only after a run of consecutive conversions above the threshold. A saturating run counter tracks that run.

A power-state machine has three named states:
- `PWR_LIVE`: the switch is allowed on.
- `PWR_OC_OFF`: the switch is off because of an overcurrent fault, either latched off or in cool-down.
- `PWR_HELD_OFF`: the switch is off because the enable pin is deasserted or because force-off is set.

The transitions are:
- `LIVE→OC_OFF` on an overcurrent event.
- `OC_OFF→LIVE` on a switch-on event.
- `any→HELD_OFF` while an off request is present. The off request has priority over all other transitions.
- `HELD_OFF→LIVE` when the off request drops.

Top module: `oc_alert_status`

## Requirements
- R1: Status bit 0 gives the result of the most recent conversion. It is 1 when the top THR_W bits of the result are strictly greater than the threshold. It updates on the clock edge that samples the done strobe, and it holds between conversions. Equality counts as not exceeding.
- R2: While the single-sample enable is high and status bit 0 is 1, the sticky converter alert (status bit 1) sets on the next edge.
- R3: While the run enable is high, status bit 1 sets one edge after the RUN_LEN-th consecutive exceeding conversion, and not before. A conversion at or below the threshold restarts the run. The counter saturates at RUN_LEN, so the run condition persists through further exceeding conversions.
- R4: An overcurrent event while the switch is live sets status bit 2 on the next edge. With the hot-swap alert enable high, the sticky hot-swap alert (status bit 3) sets one edge later. A switch-on event clears status bit 2.
- R5: An off request (enable pin low, or force-off high) sets status bit 4 on the next edge and clears status bit 2. With the off alert enable high, the sticky off alert (status bit 5) sets one edge later. Overcurrent events are ignored while the switch is held off.
- R6: The clear strobe resets all three sticky flags (bits 1, 3 and 5) on one edge. A flag whose cause is still present and enabled stays set across the clear.
- R7: The alert output is 1 exactly when at least one sticky flag is set.
- R8: After reset, with the enable pin high and force-off low, the status word and the alert are all zero.
- R9: A cause whose enable is low leaves its sticky flag clear. The live and state bits (0, 2 and 4) still follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Current conversion done strobe |
| res_data | input | RES_W | Current conversion result |
| thr | input | THR_W | Trip threshold, compared with the result's upper bits |
| en_single | input | 1 | Single-sample trip enable |
| en_run | input | 1 | Consecutive-run trip enable |
| en_hs | input | 1 | Hot-swap alert enable |
| en_off | input | 1 | Off alert enable |
| clr_stb | input | 1 | One-cycle clear of the sticky flags |
| hs_oc_evt | input | 1 | Pulse: switch turned off by overcurrent |
| hs_on_evt | input | 1 | Pulse: switch turned back on |
| en_pin | input | 1 | Enable pin level, already polarity-corrected (1 = on) |
| force_off | input | 1 | Force-off control level |
| alert | output | 1 | Active-high alert line |
| status | output | 6 | {off alert, held off, hot-swap alert, oc off, converter alert, live compare} |

## Verification
The bench uses the default parameters: a 12-bit result, an 8-bit threshold and a run length of four. With these, the full saturation behaviour of the run counter is reached within a handful of conversions. A threshold of 0x80 with results of 0x80F and 0x810 places the strictly-greater boundary in the upper byte, while the lower four bits are either all ones or all zeros. This shows that the lower bits take no part in the comparison. Every enable is toggled, so each sticky flag is seen both set and left clear for the same cause.

// File: rtl/oca_pkg.sv
`timescale 1ns/1ps
package oca_pkg;

    typedef enum logic [1:0] {
        PWR_LIVE     = 2'd0,
        PWR_OC_OFF   = 2'd1,
        PWR_HELD_OFF = 2'd2
    } pwr_state_e;

    localparam int FLAG_ADC  = 0;
    localparam int FLAG_HS   = 1;
    localparam int FLAG_OFF  = 2;
    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/cur_trip_unit.sv
`timescale 1ns/1ps
module cur_trip_unit #(
    parameter int RES_W   = 12,
    parameter int THR_W   = 8,
    parameter int RUN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic [THR_W-1:0] thr,
    output logic             live_over,
    output logic             run_full
);

    localparam int               CNT_W   = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    logic [THR_W-1:0] top_bits;
    logic             over_now;
    logic             unused_low_bits;
    logic [CNT_W-1:0] run_cnt;

    assign top_bits        = res_data[RES_W-1 -: THR_W];
    assign unused_low_bits = ^res_data[RES_W-THR_W-1:0];
    assign over_now        = (top_bits > thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_over <= 1'b0;
        end else if (res_valid) begin
            live_over <= over_now;
        end
    end

    // Consecutive-exceed counter: saturates, restarts on any non-exceeding result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (res_valid) begin
            if (!over_now) begin
                run_cnt <= '0;
            end else if (run_cnt != CNT_MAX) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign run_full = (run_cnt == CNT_MAX);

endmodule

// File: rtl/pwr_state_fsm.sv
`timescale 1ns/1ps
module pwr_state_fsm
    import oca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic off_req,
    input  logic oc_evt,
    input  logic on_evt,
    output logic oc_off,
    output logic held_off
);

    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_LIVE: begin
                if (off_req)     state_d = PWR_HELD_OFF;
                else if (oc_evt) state_d = PWR_OC_OFF;
            end
            PWR_OC_OFF: begin
                if (off_req)     state_d = PWR_HELD_OFF;
                else if (on_evt) state_d = PWR_LIVE;
            end
            PWR_HELD_OFF: begin
                if (!off_req)    state_d = PWR_LIVE;
            end
            default:             state_d = PWR_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        oc_off   = 1'b0;
        held_off = 1'b0;
        unique case (state_q)
            PWR_LIVE:     ;
            PWR_OC_OFF:   oc_off   = 1'b1;
            PWR_HELD_OFF: held_off = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/sticky_flag_bank.sv
`timescale 1ns/1ps
module sticky_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] cause,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // A present cause wins over clear, so the flag re-sets at once
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] & ~clr) | cause[i];
        end
    end

endmodule

// File: rtl/oc_alert_status.sv
`timescale 1ns/1ps
module oc_alert_status
    import oca_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int THR_W   = 8,
    parameter int RUN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic [THR_W-1:0] thr,
    input  logic             en_single,
    input  logic             en_run,
    input  logic             en_hs,
    input  logic             en_off,
    input  logic             clr_stb,
    input  logic             hs_oc_evt,
    input  logic             hs_on_evt,
    input  logic             en_pin,
    input  logic             force_off,
    output logic             alert,
    output logic [5:0]       status
);

    logic                 live_over;
    logic                 run_full;
    logic                 oc_off;
    logic                 held_off;
    logic                 off_req;
    logic [NUM_FLAGS-1:0] cause;
    logic [NUM_FLAGS-1:0] flags;

    assign off_req = ~en_pin | force_off;

    cur_trip_unit #(
        .RES_W   (RES_W),
        .THR_W   (THR_W),
        .RUN_LEN (RUN_LEN)
    ) u_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .thr       (thr),
        .live_over (live_over),
        .run_full  (run_full)
    );

    pwr_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .off_req  (off_req),
        .oc_evt   (hs_oc_evt),
        .on_evt   (hs_on_evt),
        .oc_off   (oc_off),
        .held_off (held_off)
    );

    always_comb begin
        cause           = '0;
        cause[FLAG_ADC] = (en_single & live_over) | (en_run & run_full);
        cause[FLAG_HS]  = en_hs & oc_off;
        cause[FLAG_OFF] = en_off & held_off;
    end

    sticky_flag_bank #(
        .N (NUM_FLAGS)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_stb),
        .cause (cause),
        .flags (flags)
    );

    assign alert  = |flags;
    assign status = {flags[FLAG_OFF], held_off, flags[FLAG_HS],
                     oc_off, flags[FLAG_ADC], live_over};

endmodule

// File: rtl/oc_alert_chk.sv
`timescale 1ns/1ps
module oc_alert_chk #(
    parameter int RES_W = 12,
    parameter int THR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid,
    input logic [RES_W-1:0] res_data,
    input logic [THR_W-1:0] thr,
    input logic             en_single,
    input logic             en_hs,
    input logic             en_off,
    input logic             clr_stb,
    input logic             hs_oc_evt,
    input logic             en_pin,
    input logic             force_off,
    input logic [5:0]       status
);

    a_r1_live_update: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> status[0] == ($past(res_data[RES_W-1 -: THR_W]) > $past(thr)));

    a_r1_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(status[0]));

    a_r2_single_trip: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] && en_single |=> status[1]);

    a_r4_oc_enter: assert property (@(posedge clk) disable iff (!rst_n)
        hs_oc_evt && en_pin && !force_off && !status[4] |=> status[2]);

    a_r4_hs_alert: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] && en_hs |=> status[3]);

    a_r5_off_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_pin || force_off) |=> status[4] && !status[2]);

    a_r5_off_alert: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] && en_off |=> status[5]);

    a_r6_adc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] && !clr_stb |=> status[1]);

    a_r6_hs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] && !clr_stb |=> status[3]);

    a_r6_off_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] && !clr_stb |=> status[5]);

endmodule

bind oc_alert_status oc_alert_chk #(
    .RES_W (RES_W),
    .THR_W (THR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .thr       (thr),
    .en_single (en_single),
    .en_hs     (en_hs),
    .en_off    (en_off),
    .clr_stb   (clr_stb),
    .hs_oc_evt (hs_oc_evt),
    .en_pin    (en_pin),
    .force_off (force_off),
    .status    (status)
);

// File: tb/oc_alert_status_test.sv
`timescale 1ns/1ps
module oc_alert_status_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [7:0]  thr = 8'h80;
    logic        en_single = 1'b0;
    logic        en_run = 1'b0;
    logic        en_hs = 1'b1;
    logic        en_off = 1'b1;
    logic        clr_stb = 1'b0;
    logic        hs_oc_evt = 1'b0;
    logic        hs_on_evt = 1'b0;
    logic        en_pin = 1'b1;
    logic        force_off = 1'b0;
    logic        alert;
    logic [5:0]  status;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [6:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    oc_alert_status uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .thr       (thr),
        .en_single (en_single),
        .en_run    (en_run),
        .en_hs     (en_hs),
        .en_off    (en_off),
        .clr_stb   (clr_stb),
        .hs_oc_evt (hs_oc_evt),
        .hs_on_evt (hs_on_evt),
        .en_pin    (en_pin),
        .force_off (force_off),
        .alert     (alert),
        .status    (status)
    );

    // Monitor: compare pending expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if ({alert, status} !== it.exp) begin
                    errors++;
                    $display("FAIL %s: {alert,status} got %b expected %b",
                             it.tag, {alert, status}, it.exp);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input logic a, input logic [5:0] s, input string tag);
        item_t it;
        it.exp = {a, s};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic conv(input logic [11:0] v);
        res_data  = v;
        res_valid = 1'b1;
        cyc(1);
        res_valid = 1'b0;
    endtask

    task automatic clear();
        clr_stb = 1'b1;
        cyc(1);
        clr_stb = 1'b0;
    endtask

    task automatic pulse_oc();
        hs_oc_evt = 1'b1;
        cyc(1);
        hs_oc_evt = 1'b0;
    endtask

    task automatic pulse_on();
        hs_on_evt = 1'b1;
        cyc(1);
        hs_on_evt = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        expect_st(1'b0, 6'b000000, "R8 reset state");

        // R1: equality in the upper byte does not exceed; one upper LSB more does
        conv(12'h80F);
        expect_st(1'b0, 6'b000000, "R1 equal upper byte not over");
        conv(12'h810);
        expect_st(1'b0, 6'b000001, "R1 greater upper byte over");
        cyc(1);
        expect_st(1'b0, 6'b000001, "R9 disabled trips leave flag clear");

        // R2 single-sample trip
        en_single = 1'b1;
        cyc(1);
        expect_st(1'b1, 6'b000011, "R2 single trip sets adc alert, R7 alert");
        clear();
        expect_st(1'b1, 6'b000011, "R6 clear with cause present keeps flag");
        conv(12'h7FF);
        expect_st(1'b1, 6'b000010, "R1 live drops, R6 flag sticky");
        clear();
        expect_st(1'b0, 6'b000000, "R6 clear without cause, R7 alert low");

        // R3 consecutive-run trip
        en_single = 1'b0;
        en_run    = 1'b1;
        conv(12'hA00);
        conv(12'hA00);
        conv(12'hA00);
        cyc(1);
        expect_st(1'b0, 6'b000001, "R3 three exceeding not enough");
        conv(12'hA00);
        cyc(1);
        expect_st(1'b1, 6'b000011, "R3 fourth exceeding trips");
        conv(12'hA00);
        conv(12'hA00);
        clear();
        expect_st(1'b1, 6'b000011, "R3 saturated run persists across clear");
        conv(12'h100);
        clear();
        expect_st(1'b0, 6'b000000, "R3 below restarts run, clear succeeds");
        conv(12'hA00);
        conv(12'hA00);
        conv(12'h800);
        conv(12'hA00);
        conv(12'hA00);
        conv(12'hA00);
        cyc(1);
        expect_st(1'b0, 6'b000001, "R3 equal sample broke the run");
        conv(12'hA00);
        cyc(1);
        expect_st(1'b1, 6'b000011, "R3 run completes after restart");
        conv(12'h000);
        clear();
        expect_st(1'b0, 6'b000000, "R3 cleanup");
        en_run = 1'b0;

        // R4 hot-swap overcurrent
        pulse_oc();
        expect_st(1'b0, 6'b000100, "R4 oc off state");
        cyc(1);
        expect_st(1'b1, 6'b001100, "R4 hot-swap alert sets");
        clear();
        expect_st(1'b1, 6'b001100, "R6 hot-swap cause persists");
        pulse_on();
        expect_st(1'b1, 6'b001000, "R4 switch-on clears oc off");
        clear();
        expect_st(1'b0, 6'b000000, "R6 hot-swap alert cleared");
        en_hs = 1'b0;
        pulse_oc();
        cyc(1);
        expect_st(1'b0, 6'b000100, "R9 hot-swap alert disabled");
        pulse_on();
        expect_st(1'b0, 6'b000000, "R4 back live");
        en_hs = 1'b1;

        // R5 off handling
        en_pin = 1'b0;
        cyc(1);
        expect_st(1'b0, 6'b010000, "R5 pin low held off");
        cyc(1);
        expect_st(1'b1, 6'b110000, "R5 off alert sets");
        en_pin = 1'b1;
        cyc(1);
        expect_st(1'b1, 6'b100000, "R5 pin high releases, alert sticky");
        clear();
        expect_st(1'b0, 6'b000000, "R6 off alert cleared");

        pulse_oc();
        cyc(1);
        expect_st(1'b1, 6'b001100, "R4 oc before force off");
        force_off = 1'b1;
        cyc(1);
        expect_st(1'b1, 6'b011000, "R5 force off overrides oc state");
        cyc(1);
        expect_st(1'b1, 6'b111000, "R5 force off raises off alert");
        pulse_oc();
        expect_st(1'b1, 6'b111000, "R5 oc event ignored while held off");
        force_off = 1'b0;
        conv(12'hF00);
        en_single = 1'b1;
        cyc(1);
        expect_st(1'b1, 6'b101011, "R2 adc alert with others set");
        en_single = 1'b0;
        conv(12'h000);
        clear();
        expect_st(1'b0, 6'b000000, "R6 one clear resets all three flags");

        en_off    = 1'b0;
        force_off = 1'b1;
        cyc(2);
        expect_st(1'b0, 6'b010000, "R9 off alert disabled");
        force_off = 1'b0;
        cyc(1);
        expect_st(1'b0, 6'b000000, "R5 force off released");

        cyc(2);
        finish_run();
    end

endmodule